// File: doc/BRIEF.md
# Operand Forwarding and Hazard Control for a Five-Stage Integer Pipeline

This block makes the hazard decisions for an in-order integer pipeline with the stages fetch, decode/register read, execute, memory and write back. Each cycle it looks at the source register numbers of the instruction in decode. It compares them with the destination, write-enable and load flag of the two instructions ahead of it, which sit in the decode-to-execute and execute-to-memory registers. From that comparison it decides three things: where each ALU operand will come from when the instruction reaches execute, whether the front of the pipeline must hold for a cycle, and whether the instruction fetched behind a taken branch must be squashed.

The operand selects are worked out in decode and captured in a register as the instruction advances, so execute sees them straight from a flop. The producer now in the decode-to-execute register will sit in the execute-to-memory register one cycle later, so a match against it selects the execute-to-memory path. The producer now in the execute-to-memory register will have moved on to the memory-to-writeback register, so a match against it selects the writeback path. Branches are resolved in decode. Their comparator can take a value from the execute-to-memory register, and a branch whose operand is not yet available holds for one cycle. The register file is assumed to be written in the first half of a cycle and read in the second half, so a value that is being written back needs no forward.

Top module: `fwd_hazard_unit`

## Requirements
- R1: While reset is asserted and just after it is released, both registered operand selects read 00 (register file).
- R2: A used, nonzero source register that matches the write-enabled destination in the decode-to-execute register gives select 01 (execute-to-memory value) on the cycle after the instruction leaves decode, unless a stall occurs.
- R3: A used, nonzero source register that matches only the write-enabled destination in the execute-to-memory register gives select 10 (memory-to-writeback value). When both registers match, the younger one (decode-to-execute, giving 01) wins.
- R4: Register 0 never matches, and neither does a source whose use flag is low. Such a source gives select 00 and never causes a stall.
- R5: If the decode-to-execute instruction is a load and its destination matches a used, nonzero source of the decode instruction, the block raises both the fetch hold and the bubble-insert output in that same cycle.
- R6: In the cycle after a stall, both registered operand selects read 00, because the slot that enters execute is a bubble.
- R7: A branch in decode stalls for one cycle if a used, nonzero source matches a write-enabled destination in the decode-to-execute register, or matches the destination of a load in the execute-to-memory register.
- R8: For a branch in decode that is not stalled, a branch-compare forward bit is high for each source that matches the execute-to-memory destination, and low for every other source.
- R9: The fetch flush output is high exactly when decode holds a branch marked taken and no stall occurs in that cycle.
- R10: The operand select encoding 11 never appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| id_rs1 | input | REG_W | First source register of the decode instruction |
| id_rs2 | input | REG_W | Second source register of the decode instruction |
| id_use_rs1 | input | 1 | Decode instruction reads its first source |
| id_use_rs2 | input | 1 | Decode instruction reads its second source |
| id_is_branch | input | 1 | Decode instruction is a conditional branch |
| id_br_taken | input | 1 | The branch comparator says taken |
| idex_rd | input | REG_W | Destination of the instruction in decode-to-execute |
| idex_we | input | 1 | That instruction writes a register |
| idex_load | input | 1 | That instruction is a load |
| exmem_rd | input | REG_W | Destination of the instruction in execute-to-memory |
| exmem_we | input | 1 | That instruction writes a register |
| exmem_load | input | 1 | That instruction is a load |
| ex_sel_a | output | 2 | Registered select for ALU operand A: 00 file, 01 exec-to-mem, 10 mem-to-wb |
| ex_sel_b | output | 2 | Registered select for ALU operand B, same encoding |
| br_fwd_a | output | 1 | Branch comparator takes operand A from exec-to-mem |
| br_fwd_b | output | 1 | Branch comparator takes operand B from exec-to-mem |
| hold_fetch | output | 1 | Hold the PC and the fetch-to-decode register |
| idex_bubble | output | 1 | Load a no-op with write-enable cleared into decode-to-execute |
| if_flush | output | 1 | Squash the instruction in the fetch-to-decode register |

## Verification
The bench builds the block with REG_W set to 3, which leaves only eight registers. With so few registers, random instruction streams run into back-to-back dependencies, double matches in both older stages, load-use pairs and branches waiting on a load all the time. Writes to register 0 and sources that are not used also come up often, so the zero-register and use-flag masking get a workout. A behavioural model of the three pipeline slots in the bench moves with each stall, bubble and flush. Every cycle it predicts the stall, flush and branch-forward outputs and the registered selects.

// File: rtl/fwd_hazard_unit.sv
module fwd_hazard_unit #(
  parameter int REG_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [REG_W-1:0] id_rs1,
  input  logic [REG_W-1:0] id_rs2,
  input  logic             id_use_rs1,
  input  logic             id_use_rs2,
  input  logic             id_is_branch,
  input  logic             id_br_taken,
  input  logic [REG_W-1:0] idex_rd,
  input  logic             idex_we,
  input  logic             idex_load,
  input  logic [REG_W-1:0] exmem_rd,
  input  logic             exmem_we,
  input  logic             exmem_load,
  output logic [1:0]       ex_sel_a,
  output logic [1:0]       ex_sel_b,
  output logic             br_fwd_a,
  output logic             br_fwd_b,
  output logic             hold_fetch,
  output logic             idex_bubble,
  output logic             if_flush
);

  localparam logic [1:0] SEL_RF  = 2'b00;
  localparam logic [1:0] SEL_EXM = 2'b01;
  localparam logic [1:0] SEL_MWB = 2'b10;

  logic live_a, live_b;
  logic a_near, b_near, a_far, b_far;
  logic load_use, br_wait, stall;
  logic [1:0] nxt_a, nxt_b;

  assign live_a = id_use_rs1 && (id_rs1 != '0);
  assign live_b = id_use_rs2 && (id_rs2 != '0);

  assign a_near = live_a && idex_we && (idex_rd == id_rs1);
  assign b_near = live_b && idex_we && (idex_rd == id_rs2);
  assign a_far  = live_a && exmem_we && (exmem_rd == id_rs1);
  assign b_far  = live_b && exmem_we && (exmem_rd == id_rs2);

  assign load_use = idex_load && (a_near || b_near);
  assign br_wait  = id_is_branch &&
                    (a_near || b_near || (exmem_load && (a_far || b_far)));
  assign stall    = load_use || br_wait;

  assign nxt_a = stall ? SEL_RF : a_near ? SEL_EXM : a_far ? SEL_MWB : SEL_RF;
  assign nxt_b = stall ? SEL_RF : b_near ? SEL_EXM : b_far ? SEL_MWB : SEL_RF;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ex_sel_a <= SEL_RF;
      ex_sel_b <= SEL_RF;
    end else begin
      ex_sel_a <= nxt_a;
      ex_sel_b <= nxt_b;
    end
  end

  assign br_fwd_a    = id_is_branch && !stall && a_far;
  assign br_fwd_b    = id_is_branch && !stall && b_far;
  assign hold_fetch  = stall;
  assign idex_bubble = stall;
  assign if_flush    = id_is_branch && id_br_taken && !stall;

  a_r5_load_use_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (idex_we && idex_load && id_use_rs1 && id_rs1 != '0 && id_rs1 == idex_rd)
      |-> (hold_fetch && idex_bubble));

  a_r6_bubble_clears_sel: assert property (@(posedge clk) disable iff (!rst_n)
    idex_bubble |=> (ex_sel_a == SEL_RF && ex_sel_b == SEL_RF));

  a_r4_zero_reg_from_file: assert property (@(posedge clk) disable iff (!rst_n)
    (id_rs1 == '0 && id_rs2 == '0) |=> (ex_sel_a == SEL_RF && ex_sel_b == SEL_RF));

  a_r10_sel_legal: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_sel_a != 2'b11 && ex_sel_b != 2'b11));

  a_r9_flush_only_unstalled: assert property (@(posedge clk) disable iff (!rst_n)
    if_flush |-> (id_is_branch && id_br_taken && !hold_fetch));

  a_r8_brfwd_alu_only: assert property (@(posedge clk) disable iff (!rst_n)
    (br_fwd_a || br_fwd_b) |-> (exmem_we && !exmem_load && !hold_fetch));

endmodule

// File: tb/fwd_hazard_unit_test.sv
module fwd_hazard_unit_test;
  localparam int CLK_PERIOD = 10;
  localparam int RW = 3;
  localparam int NCYC = 3000;

  logic clk = 0;
  logic rst_n = 0;
  always #(CLK_PERIOD/2) clk = ~clk;

  int m_rs1, m_rs2, m_rd;
  bit m_u1, m_u2, m_br, m_tk, m_we, m_ld;
  int x_rd, y_rd;
  bit x_we, x_ld, y_we, y_ld;

  logic [1:0] ex_sel_a, ex_sel_b;
  logic br_fwd_a, br_fwd_b, hold_fetch, idex_bubble, if_flush;

  fwd_hazard_unit #(.REG_W(RW)) uut (
    .clk(clk), .rst_n(rst_n),
    .id_rs1(RW'(m_rs1)), .id_rs2(RW'(m_rs2)),
    .id_use_rs1(m_u1), .id_use_rs2(m_u2),
    .id_is_branch(m_br), .id_br_taken(m_tk),
    .idex_rd(RW'(x_rd)), .idex_we(x_we), .idex_load(x_ld),
    .exmem_rd(RW'(y_rd)), .exmem_we(y_we), .exmem_load(y_ld),
    .ex_sel_a(ex_sel_a), .ex_sel_b(ex_sel_b),
    .br_fwd_a(br_fwd_a), .br_fwd_b(br_fwd_b),
    .hold_fetch(hold_fetch), .idex_bubble(idex_bubble), .if_flush(if_flush)
  );

  int vectors = 0;
  int misses = 0;
  int cyc = 0;
  bit done = 0;

  task automatic chk(string req, int act, int exp);
    vectors++;
    if (act != exp) begin
      misses++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic clear_id();
    m_rs1 = 0; m_rs2 = 0; m_rd = 0;
    m_u1 = 0; m_u2 = 0; m_br = 0; m_tk = 0; m_we = 0; m_ld = 0;
  endtask

  task automatic new_instr();
    int kind = $urandom_range(0, 9);
    clear_id();
    m_rs1 = $urandom_range(0, (1 << RW) - 1);
    m_rs2 = $urandom_range(0, (1 << RW) - 1);
    m_rd  = $urandom_range(0, (1 << RW) - 1);
    m_u1 = ($urandom_range(0, 9) != 0);
    m_u2 = ($urandom_range(0, 3) != 0);
    if (kind < 2) begin m_br = 1; m_tk = $urandom_range(0, 1); end
    else if (kind < 5) begin m_we = 1; m_ld = 1; m_u2 = 0; end
    else if (kind < 9) m_we = 1;
  endtask

  // Youngest older producer: 1 = decode-to-execute slot, 2 = execute-to-memory slot
  function automatic int producer(bit used, int src);
    if (!used || src == 0) return 0;
    if (x_we && x_rd == src) return 1;
    if (y_we && y_rd == src) return 2;
    return 0;
  endfunction

  int exp_sa_q = 0, exp_sb_q = 0;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 200000 && !done) begin
      misses++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, NCYC);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

  initial begin
    clear_id();
    x_rd = 0; x_we = 0; x_ld = 0; y_rd = 0; y_we = 0; y_ld = 0;
    m_rs1 = 1; m_u1 = 1; x_rd = 1; x_we = 1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 sel_a in reset", ex_sel_a, 0);
    chk("R1 sel_b in reset", ex_sel_b, 0);
    rst_n = 1;
    x_rd = 0; x_we = 0;
    clear_id();
    @(negedge clk);
    chk("R1 sel_a after reset", ex_sel_a, 0);
    chk("R1 sel_b after reset", ex_sel_b, 0);
    new_instr();

    for (int i = 0; i < NCYC; i++) begin
      int fa, fb, ea, eb;
      bit stall, eflush;
      @(negedge clk);
      #1;
      fa = producer(m_u1, m_rs1);
      fb = producer(m_u2, m_rs2);
      stall = (x_ld && (fa == 1 || fb == 1)) ||
              (m_br && (fa == 1 || fb == 1 || (y_ld && (fa == 2 || fb == 2))));
      chk("R2 R3 R4 R6 R10 ex_sel_a", ex_sel_a, exp_sa_q);
      chk("R2 R3 R4 R6 R10 ex_sel_b", ex_sel_b, exp_sb_q);
      chk("R5 R7 hold_fetch", hold_fetch, stall);
      chk("R5 R7 idex_bubble", idex_bubble, stall);
      chk("R8 br_fwd_a", br_fwd_a, m_br && !stall && fa == 2);
      chk("R8 br_fwd_b", br_fwd_b, m_br && !stall && fb == 2);
      eflush = m_br && m_tk && !stall;
      chk("R9 if_flush", if_flush, eflush);
      ea = stall ? 0 : fa == 1 ? 1 : fa == 2 ? 2 : 0;
      eb = stall ? 0 : fb == 1 ? 1 : fb == 2 ? 2 : 0;
      @(posedge clk);
      #1;
      exp_sa_q = ea;
      exp_sb_q = eb;
      y_rd = x_rd; y_we = x_we; y_ld = x_ld;
      if (stall) begin
        x_rd = 0; x_we = 0; x_ld = 0;
      end else begin
        x_rd = m_rd; x_we = m_we; x_ld = m_ld;
        if (eflush) clear_id();
        else new_instr();
      end
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule